// File: doc/BRIEF.md
# Enhanced Parallel Port Host Controller

This block is the host side of an enhanced parallel port. A processor reaches it through a small byte-addressed register bus with eight offsets. Accesses to the port's address register or data register are turned into complete interlocked byte cycles on the cable. Each cycle drives a write line, a data strobe or an address strobe, and the multiplexed 8-bit AD bus. Every step waits on the peripheral's Wait# line, so software never toggles pins itself. A 16-bit or 32-bit access to the data register becomes two or four back-to-back byte cycles, least significant byte first.

When no cycle is running, the legacy data and control registers drive the pins directly. A sticky status bit records a handshake that stalls for longer than a build-time cycle count. When that happens the controller drops the strobe, abandons the rest of the access, and completes the bus transfer so the processor is not held.

Top module: `epp_host_ctrl`

## Requirements
- R1: Bus offsets 0 to 2 complete locally, with `bus_ack_o` one cycle after the request is taken. Offset 0 stores a byte that drives `ad_o` when idle and control bit 5 is 0 (`ad_oe_o` = 1), and a read of offset 0 returns the level on `ad_i`.
- R2: While no cycle runs, the idle pin levels are `n_write_o` = ~ctrl[0], `n_dstb_o` = ~ctrl[1], `n_astb_o` = ~ctrl[3] and `n_rst_o` = ctrl[2], and `ad_oe_o` = ~ctrl[5]. The control register (offset 2) resets to 0x04 and reads back as written.
- R3: A read of offset 1 returns bit 0 as the timeout flag, bit 6 as the level of `n_intr_i`, bit 7 as the inverse of the synchronised `n_wait_i`, and zeros in the other bits.
- R4: A write cycle first pulls `n_write_o` low and drives the byte with `ad_oe_o` = 1. Only after `n_wait_i` is seen low does it lower the strobe.
- R5: A strobe stays low until `n_wait_i` is seen high and is then released. On a write, `n_write_o` and the data stay steady for the whole strobe.
- R6: Offset 3 runs the cycle with `n_astb_o`. Offsets 4 to 7 run it with `n_dstb_o`. The two strobes are never low together.
- R7: A read cycle keeps `n_write_o` high and `ad_oe_o` = 0, and captures `ad_i` when `n_wait_i` is seen high during the strobe. A single-byte read returns the byte in `bus_rdata_o[7:0]` with the upper bits zero.
- R8: `bus_size_i` encodes 0 = byte, 1 = 16-bit, 2 = 32-bit, and 3 acts as byte. At offset 4, sizes 1 and 2 give 2 and 4 data cycles taking `bus_wdata_i` bytes from bit 0 upward. Reads place the first byte in `bus_rdata_o[7:0]`. Offsets 3 and 5 to 7 always run one cycle.
- R9: If `n_wait_i` does not answer within TMO_CYCLES cycles in either wait phase, the strobe is released and the remaining bytes are dropped. The access is then acknowledged and status bit 0 is set.
- R10: Writing offset 1 with bit 0 = 1 clears the timeout flag. Writing it with bit 0 = 0 leaves the flag unchanged.
- R11: `bus_ack_o` is a single-cycle pulse, given exactly once for each access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Access request, held until acknowledged |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Register offset |
| bus_size_i | input | 2 | Access width code |
| bus_wdata_i | input | 32 | Write data |
| bus_ack_o | output | 1 | Access complete pulse |
| bus_rdata_o | output | 32 | Read data, valid with ack |
| ad_i | input | 8 | AD bus input |
| ad_o | output | 8 | AD bus output |
| ad_oe_o | output | 1 | AD bus drive enable |
| n_write_o | output | 1 | Write direction, active low |
| n_dstb_o | output | 1 | Data strobe, active low |
| n_astb_o | output | 1 | Address strobe, active low |
| n_rst_o | output | 1 | Peripheral reset, active low |
| n_wait_i | input | 1 | Peripheral wait/ready |
| n_intr_i | input | 1 | Peripheral interrupt level |

## Verification
The bench builds the controller with TMO_CYCLES = 40 and the default two-stage Wait# synchroniser. This keeps the timeout cycles short, so the bench can reach a stall in the Wait#-low phase and a stall in the strobe phase, and can confirm that a 32-bit access stops after its first byte. A peripheral model that answers after a fixed delay covers the interlocked ordering, byte splitting and read capture. Its stall modes cover the recovery paths.

// File: rtl/epp_pkg.sv
package epp_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} acc_size_e;
  typedef enum logic [1:0] {HS_IDLE, HS_WAITLO, HS_STB, HS_DONE} hs_state_e;
  typedef enum logic {SQ_IDLE, SQ_RUN} sq_state_e;
  localparam logic [2:0] OFF_SPP  = 3'd0;
  localparam logic [2:0] OFF_STAT = 3'd1;
  localparam logic [2:0] OFF_CTRL = 3'd2;
  localparam logic [2:0] OFF_ADDR = 3'd3;
  localparam logic [2:0] OFF_DATA = 3'd4;
  localparam logic [7:0] CTRL_RST = 8'h04;
endpackage

// File: rtl/epp_sync.sv
module epp_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < int'(STAGES); i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[i] <= RST_VAL;
        else if (i == 0) chain_q[i] <= d_i;
        else chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/epp_regs.sv
module epp_regs import epp_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_spp_i,
  input  logic       wr_ctrl_i,
  input  logic       wr_stat_i,
  input  logic [7:0] wdata_i,
  input  logic       tmo_set_i,
  output logic [7:0] spp_q_o,
  output logic [7:0] ctrl_q_o,
  output logic       tmo_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spp_q_o  <= '0;
      ctrl_q_o <= CTRL_RST;
      tmo_q_o  <= 1'b0;
    end else begin
      if (wr_spp_i)  spp_q_o  <= wdata_i;
      if (wr_ctrl_i) ctrl_q_o <= wdata_i;
      if (tmo_set_i) tmo_q_o <= 1'b1;
      else if (wr_stat_i && wdata_i[0]) tmo_q_o <= 1'b0;
    end
  end
endmodule

// File: rtl/epp_handshake.sv
module epp_handshake import epp_pkg::*; #(
  parameter int unsigned TMO_CYCLES = 500
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       is_read_i,
  input  logic       is_addr_i,
  input  logic [7:0] byte_i,
  input  logic       wait_s_i,
  input  logic [7:0] ad_i,
  output logic       active_o,
  output logic       n_write_o,
  output logic       n_dstb_o,
  output logic       n_astb_o,
  output logic       ad_oe_o,
  output logic [7:0] ad_o,
  output logic       done_o,
  output logic       tmo_o,
  output logic [7:0] rd_byte_o
);
  localparam int unsigned CW = $clog2(TMO_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(TMO_CYCLES - 1);

  hs_state_e      st_q;
  logic [CW-1:0]  cnt_q;
  logic           rd_q, adr_q, tmo_q;
  logic [7:0]     byte_q, cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= HS_IDLE;
      cnt_q  <= '0;
      rd_q   <= 1'b0;
      adr_q  <= 1'b0;
      tmo_q  <= 1'b0;
      byte_q <= '0;
      cap_q  <= '0;
    end else begin
      unique case (st_q)
        HS_IDLE: if (start_i) begin
          st_q   <= HS_WAITLO;
          cnt_q  <= '0;
          rd_q   <= is_read_i;
          adr_q  <= is_addr_i;
          byte_q <= byte_i;
          tmo_q  <= 1'b0;
        end
        HS_WAITLO: begin
          if (!wait_s_i) begin
            st_q  <= HS_STB;
            cnt_q <= '0;
          end else if (cnt_q == CNT_LAST) begin
            st_q  <= HS_DONE;
            tmo_q <= 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
        HS_STB: begin
          if (wait_s_i) begin
            st_q  <= HS_DONE;
            cap_q <= ad_i;
          end else if (cnt_q == CNT_LAST) begin
            st_q  <= HS_DONE;
            tmo_q <= 1'b1;
            cap_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        HS_DONE: begin
          st_q  <= HS_IDLE;
          tmo_q <= 1'b0;
        end
        default: st_q <= HS_IDLE;
      endcase
    end
  end

  assign active_o  = (st_q != HS_IDLE);
  assign n_write_o = !(active_o && !rd_q);
  assign ad_oe_o   = active_o && !rd_q;
  assign ad_o      = byte_q;
  assign n_dstb_o  = !((st_q == HS_STB) && !adr_q);
  assign n_astb_o  = !((st_q == HS_STB) && adr_q);
  assign done_o    = (st_q == HS_DONE);
  assign tmo_o     = tmo_q;
  assign rd_byte_o = cap_q;
endmodule

// File: rtl/epp_sequencer.sv
module epp_sequencer import epp_pkg::*; #(
  parameter int unsigned BUS_BYTES = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [2:0]             addr_i,
  input  logic [1:0]             size_i,
  input  logic [8*BUS_BYTES-1:0] wdata_i,
  output logic                   ack_o,
  output logic [8*BUS_BYTES-1:0] rdata_o,
  input  logic [7:0]             pin_data_i,
  input  logic [7:0]             status_i,
  input  logic [7:0]             ctrl_i,
  output logic                   wr_spp_o,
  output logic                   wr_ctrl_o,
  output logic                   wr_stat_o,
  output logic                   tmo_set_o,
  output logic                   hs_start_o,
  output logic                   hs_read_o,
  output logic                   hs_addr_o,
  output logic [7:0]             hs_byte_o,
  input  logic                   hs_done_i,
  input  logic                   hs_tmo_i,
  input  logic [7:0]             hs_rd_byte_i
);
  localparam int unsigned BW    = 8 * BUS_BYTES;
  localparam int unsigned IDX_W = (BUS_BYTES > 1) ? $clog2(BUS_BYTES) : 1;

  sq_state_e        sq_q;
  logic [IDX_W-1:0] idx_q, last_q, last_d;
  logic [BW-1:0]    wbuf_q, rbuf_q, rbuf_d, rdata_q;
  logic             ack_q, start_q, rd_q, adr_q;
  logic             accept, is_epp, finish;
  logic [7:0]       local_byte;

  assign accept = req_i && !ack_q && (sq_q == SQ_IDLE);
  assign is_epp = (addr_i >= OFF_ADDR);
  assign finish = (sq_q == SQ_RUN) && hs_done_i && (hs_tmo_i || idx_q == last_q);

  assign wr_spp_o  = accept && we_i && (addr_i == OFF_SPP);
  assign wr_stat_o = accept && we_i && (addr_i == OFF_STAT);
  assign wr_ctrl_o = accept && we_i && (addr_i == OFF_CTRL);
  assign tmo_set_o = (sq_q == SQ_RUN) && hs_done_i && hs_tmo_i;

  always_comb begin
    last_d = '0;
    if (addr_i == OFF_DATA) begin
      unique case (size_i)
        SZ_HALF: last_d = IDX_W'((BUS_BYTES > 1) ? 1 : 0);
        SZ_WORD: last_d = IDX_W'(BUS_BYTES - 1);
        default: last_d = '0;
      endcase
    end
  end

  always_comb begin
    unique case (addr_i)
      OFF_SPP:  local_byte = pin_data_i;
      OFF_STAT: local_byte = status_i;
      OFF_CTRL: local_byte = ctrl_i;
      default:  local_byte = '0;
    endcase
  end

  always_comb begin
    rbuf_d = rbuf_q;
    rbuf_d[idx_q*8 +: 8] = rd_q ? hs_rd_byte_i : 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq_q    <= SQ_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
      wbuf_q  <= '0;
      rbuf_q  <= '0;
      rdata_q <= '0;
      ack_q   <= 1'b0;
      start_q <= 1'b0;
      rd_q    <= 1'b0;
      adr_q   <= 1'b0;
    end else begin
      ack_q   <= 1'b0;
      start_q <= 1'b0;
      unique case (sq_q)
        SQ_IDLE: if (accept) begin
          if (is_epp) begin
            sq_q    <= SQ_RUN;
            rd_q    <= !we_i;
            adr_q   <= (addr_i == OFF_ADDR);
            last_q  <= last_d;
            idx_q   <= '0;
            wbuf_q  <= wdata_i;
            rbuf_q  <= '0;
            start_q <= 1'b1;
          end else begin
            ack_q   <= 1'b1;
            rdata_q <= {{(BW-8){1'b0}}, we_i ? 8'h00 : local_byte};
          end
        end
        SQ_RUN: if (hs_done_i) begin
          rbuf_q <= rbuf_d;
          if (finish) begin
            sq_q    <= SQ_IDLE;
            ack_q   <= 1'b1;
            rdata_q <= rbuf_d;
          end else begin
            idx_q   <= idx_q + 1'b1;
            start_q <= 1'b1;
          end
        end
        default: sq_q <= SQ_IDLE;
      endcase
    end
  end

  assign ack_o      = ack_q;
  assign rdata_o    = rdata_q;
  assign hs_start_o = start_q;
  assign hs_read_o  = rd_q;
  assign hs_addr_o  = adr_q;
  assign hs_byte_o  = wbuf_q[idx_q*8 +: 8];
endmodule

// File: rtl/epp_host_ctrl.sv
module epp_host_ctrl import epp_pkg::*; #(
  parameter int unsigned BUS_BYTES   = 4,
  parameter int unsigned TMO_CYCLES  = 500,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   bus_req_i,
  input  logic                   bus_we_i,
  input  logic [2:0]             bus_addr_i,
  input  logic [1:0]             bus_size_i,
  input  logic [8*BUS_BYTES-1:0] bus_wdata_i,
  output logic                   bus_ack_o,
  output logic [8*BUS_BYTES-1:0] bus_rdata_o,
  input  logic [7:0]             ad_i,
  output logic [7:0]             ad_o,
  output logic                   ad_oe_o,
  output logic                   n_write_o,
  output logic                   n_dstb_o,
  output logic                   n_astb_o,
  output logic                   n_rst_o,
  input  logic                   n_wait_i,
  input  logic                   n_intr_i
);
  logic       wait_s;
  logic [7:0] spp_q, ctrl_q, status;
  logic       tmo_q, tmo_set, wr_spp, wr_ctrl, wr_stat;
  logic       hs_start, hs_read, hs_addr, hs_done, hs_tmo, hs_active;
  logic       hs_n_write, hs_n_dstb, hs_n_astb, hs_ad_oe;
  logic [7:0] hs_byte, hs_rd_byte, hs_ad;

  epp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_wait_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(n_wait_i), .q_o(wait_s)
  );

  assign status = {~wait_s, n_intr_i, 5'b0, tmo_q};

  epp_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_spp_i(wr_spp), .wr_ctrl_i(wr_ctrl), .wr_stat_i(wr_stat),
    .wdata_i(bus_wdata_i[7:0]), .tmo_set_i(tmo_set),
    .spp_q_o(spp_q), .ctrl_q_o(ctrl_q), .tmo_q_o(tmo_q)
  );

  epp_sequencer #(.BUS_BYTES(BUS_BYTES)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_i(bus_req_i), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .size_i(bus_size_i), .wdata_i(bus_wdata_i),
    .ack_o(bus_ack_o), .rdata_o(bus_rdata_o),
    .pin_data_i(ad_i), .status_i(status), .ctrl_i(ctrl_q),
    .wr_spp_o(wr_spp), .wr_ctrl_o(wr_ctrl), .wr_stat_o(wr_stat),
    .tmo_set_o(tmo_set),
    .hs_start_o(hs_start), .hs_read_o(hs_read), .hs_addr_o(hs_addr),
    .hs_byte_o(hs_byte), .hs_done_i(hs_done), .hs_tmo_i(hs_tmo),
    .hs_rd_byte_i(hs_rd_byte)
  );

  epp_handshake #(.TMO_CYCLES(TMO_CYCLES)) u_hs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(hs_start), .is_read_i(hs_read), .is_addr_i(hs_addr),
    .byte_i(hs_byte), .wait_s_i(wait_s), .ad_i(ad_i),
    .active_o(hs_active), .n_write_o(hs_n_write), .n_dstb_o(hs_n_dstb),
    .n_astb_o(hs_n_astb), .ad_oe_o(hs_ad_oe), .ad_o(hs_ad),
    .done_o(hs_done), .tmo_o(hs_tmo), .rd_byte_o(hs_rd_byte)
  );

  // handshake owns the strobe pins while a byte cycle runs
  assign n_write_o = hs_active ? hs_n_write : ~ctrl_q[0];
  assign n_dstb_o  = hs_active ? hs_n_dstb  : ~ctrl_q[1];
  assign n_astb_o  = hs_active ? hs_n_astb  : ~ctrl_q[3];
  assign ad_oe_o   = hs_active ? hs_ad_oe   : ~ctrl_q[5];
  assign ad_o      = hs_active ? hs_ad      : spp_q;
  assign n_rst_o   = ctrl_q[2];
endmodule

// File: rtl/epp_host_ctrl_chk.sv
module epp_host_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wait_s,
  input logic hs_n_dstb,
  input logic hs_n_astb,
  input logic hs_n_write,
  input logic hs_ad_oe,
  input logic hs_tmo,
  input logic n_dstb_o,
  input logic n_astb_o,
  input logic n_write_o,
  input logic [7:0] ad_o,
  input logic bus_ack_o
);
  logic stb_n;
  assign stb_n = hs_n_dstb & hs_n_astb;

  a_r4_strobe_after_wait_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stb_n) |-> $past(!wait_s));

  a_r5_release_after_wait_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stb_n) |-> ($past(wait_s) || hs_tmo));

  a_r5_write_steady_in_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stb_n && $past(!stb_n)) |-> ($stable(n_write_o) && $stable(ad_o)));

  a_r6_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!n_dstb_o && !n_astb_o && !stb_n));

  a_r7_drive_follows_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_n |-> (hs_ad_oe == !hs_n_write));

  a_r11_ack_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ack_o |=> !bus_ack_o);
endmodule

bind epp_host_ctrl epp_host_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wait_s(wait_s),
  .hs_n_dstb(hs_n_dstb), .hs_n_astb(hs_n_astb), .hs_n_write(hs_n_write),
  .hs_ad_oe(hs_ad_oe), .hs_tmo(hs_tmo),
  .n_dstb_o(n_dstb_o), .n_astb_o(n_astb_o), .n_write_o(n_write_o),
  .ad_o(ad_o), .bus_ack_o(bus_ack_o)
);

// File: tb/sim_epp_host_ctrl.sv
`timescale 1ns/1ps
module sim_epp_host_ctrl;
  localparam int TMO = 40;
  localparam int DLY = 2;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic        ack;
  logic [31:0] rdata;
  logic [7:0]  ad_in = 8'h5A, ad_out;
  logic        ad_oe, n_write, n_dstb, n_astb, n_rst;
  logic        n_wait = 1'b0, n_intr = 1'b1;

  int total = 0, fails = 0;
  logic [9:0] exp_q[$];   // {is_addr, is_write, byte}
  logic [7:0] rdq[$];
  logic       per_en = 1'b0, stuck = 1'b0;
  int         pst = 0, pcnt = 0;

  always #10 clk = ~clk;

  epp_host_ctrl #(.BUS_BYTES(4), .TMO_CYCLES(TMO), .SYNC_STAGES(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_size_i(size), .bus_wdata_i(wdata),
    .bus_ack_o(ack), .bus_rdata_o(rdata), .ad_i(ad_in), .ad_o(ad_out),
    .ad_oe_o(ad_oe), .n_write_o(n_write), .n_dstb_o(n_dstb),
    .n_astb_o(n_astb), .n_rst_o(n_rst), .n_wait_i(n_wait), .n_intr_i(n_intr)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, expv);
    end
  endtask

  task automatic bus(input logic w, input logic [2:0] a, input logic [1:0] s,
                     input logic [31:0] d, output logic [31:0] q, output int cyc);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; size = s; wdata = d; cyc = 0;
    do begin @(negedge clk); cyc++; end while (!ack);
    q = rdata;
    req = 1'b0;
    @(negedge clk);
    chk("R11 ack single pulse", {31'b0, ack}, 32'd0);
  endtask

  task automatic expect_item(input logic is_a, input logic is_w, input logic [7:0] b);
    exp_q.push_back({is_a, is_w, b});
  endtask

  // peripheral model and scoreboard monitor
  always @(negedge clk) begin
    if (per_en) begin
      case (pst)
        0: if (!n_dstb || !n_astb) begin pcnt = DLY; pst = 1; end
        1: if (pcnt > 0) pcnt--;
           else begin
             if (!stuck) begin
               logic [9:0] got;
               if (n_write) ad_in = (rdq.size() > 0) ? rdq.pop_front() : 8'hEE;
               got = {!n_astb, !n_write, n_write ? ad_in : ad_out};
               total++;
               if (exp_q.size() == 0) begin
                 fails++;
                 $display("FAIL R8 scoreboard: actual %h expected none", got);
               end else begin
                 logic [9:0] e;
                 e = exp_q.pop_front();
                 if (got !== e) begin
                   fails++;
                   $display("FAIL R4/R6/R7 cycle: actual %h expected %h", got, e);
                 end
               end
               n_wait = 1'b1;
             end
             pst = 2;
           end
        2: if (n_dstb && n_astb) begin pcnt = DLY; pst = 3; end
        3: if (pcnt > 0) pcnt--; else begin n_wait = 1'b0; pst = 0; end
        default: pst = 0;
      endcase
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual hang expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] q;
    int cyc;
    repeat (3) @(negedge clk);
    chk("R2 reset pins", {27'b0, n_write, n_dstb, n_astb, n_rst, ad_oe}, 32'h1F);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    bus(1'b0, 3'd2, 2'd0, 0, q, cyc);
    chk("R2 ctrl reset value", q, 32'h04);
    chk("R1 local ack latency", cyc, 1);
    bus(1'b0, 3'd1, 2'd0, 0, q, cyc);
    chk("R3 status idle", q, 32'hC0);
    bus(1'b1, 3'd0, 2'd0, 32'hA5, q, cyc);
    chk("R1 spp data on pins", {23'b0, ad_oe, ad_out}, 32'h1A5);
    bus(1'b0, 3'd0, 2'd0, 0, q, cyc);
    chk("R1 spp read of pins", q, 32'h5A);
    bus(1'b1, 3'd2, 2'd0, 32'h2B, q, cyc);
    chk("R2 ctrl pass-through", {27'b0, n_write, n_dstb, n_astb, n_rst, ad_oe}, 32'h00);
    bus(1'b0, 3'd2, 2'd0, 0, q, cyc);
    chk("R2 ctrl readback", q, 32'h2B);
    bus(1'b1, 3'd2, 2'd0, 32'h04, q, cyc);
    per_en = 1'b1;

    expect_item(1'b1, 1'b1, 8'h3C);
    bus(1'b1, 3'd3, 2'd0, 32'h3C, q, cyc);
    expect_item(1'b0, 1'b1, 8'h81);
    bus(1'b1, 3'd4, 2'd0, 32'h81, q, cyc);
    expect_item(1'b0, 1'b1, 8'h34); expect_item(1'b0, 1'b1, 8'h12);
    bus(1'b1, 3'd4, 2'd1, 32'h1234, q, cyc);
    expect_item(1'b0, 1'b1, 8'h44); expect_item(1'b0, 1'b1, 8'h33);
    expect_item(1'b0, 1'b1, 8'h22); expect_item(1'b0, 1'b1, 8'h11);
    bus(1'b1, 3'd4, 2'd2, 32'h11223344, q, cyc);
    expect_item(1'b0, 1'b1, 8'h77);
    bus(1'b1, 3'd6, 2'd2, 32'hAABBCC77, q, cyc);
    chk("R8 all write bytes seen", exp_q.size(), 0);

    rdq.push_back(8'h9E); expect_item(1'b1, 1'b0, 8'h9E);
    bus(1'b0, 3'd3, 2'd0, 0, q, cyc);
    chk("R7 address read", q, 32'h9E);
    rdq.push_back(8'hAA); rdq.push_back(8'hBB); rdq.push_back(8'hCC); rdq.push_back(8'hDD);
    expect_item(1'b0, 1'b0, 8'hAA); expect_item(1'b0, 1'b0, 8'hBB);
    expect_item(1'b0, 1'b0, 8'hCC); expect_item(1'b0, 1'b0, 8'hDD);
    bus(1'b0, 3'd4, 2'd2, 0, q, cyc);
    chk("R8 word read assembly", q, 32'hDDCCBBAA);
    rdq.push_back(8'h61); rdq.push_back(8'h62);
    expect_item(1'b0, 1'b0, 8'h61); expect_item(1'b0, 1'b0, 8'h62);
    bus(1'b0, 3'd4, 2'd1, 0, q, cyc);
    chk("R8 half read assembly", q, 32'h6261);
    bus(1'b0, 3'd1, 2'd0, 0, q, cyc);
    chk("R9 no timeout on normal traffic", q[0], 1'b0);

    // peripheral never ready: stall in the wait-low phase
    n_wait = 1'b1;
    repeat (4) @(negedge clk);
    bus(1'b1, 3'd4, 2'd2, 32'hDEADBEEF, q, cyc);
    total++;
    if (cyc < TMO || cyc > TMO + 8) begin
      fails++;
      $display("FAIL R9 abort after first byte: actual %0d expected %0d..%0d", cyc, TMO, TMO + 8);
    end
    chk("R9 strobes released", {30'b0, n_dstb, n_astb}, 32'h3);
    bus(1'b0, 3'd1, 2'd0, 0, q, cyc);
    chk("R9 flag set", q, 32'h41);
    bus(1'b1, 3'd1, 2'd0, 32'h00, q, cyc);
    bus(1'b0, 3'd1, 2'd0, 0, q, cyc);
    chk("R10 write 0 keeps flag", q[0], 1'b1);
    bus(1'b1, 3'd1, 2'd0, 32'h01, q, cyc);
    n_wait = 1'b0;
    repeat (4) @(negedge clk);
    bus(1'b0, 3'd1, 2'd0, 0, q, cyc);
    chk("R10 write 1 clears flag", q, 32'hC0);

    // peripheral takes the strobe but never raises wait
    stuck = 1'b1;
    bus(1'b1, 3'd4, 2'd0, 32'h55, q, cyc);
    chk("R9 strobe dropped on stall", {31'b0, n_dstb}, 32'h1);
    bus(1'b0, 3'd1, 2'd0, 0, q, cyc);
    chk("R9 flag after strobe stall", q[0], 1'b1);
    stuck = 1'b0;
    repeat (8) @(negedge clk);
    chk("R9 no cycles after abort", exp_q.size(), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule